// File: doc/BRIEF.md
# Segmented MMIO Window Partition Decoder

This block sits on the outbound path of a host bridge. For each CPU address it is given, it decides which of its address windows claims the access. It then produces the address to drive on the PCIe side and an 8-bit partition number, which downstream isolation logic uses. There are two kinds of window.

- **The narrow window** is a single window of at most 4 GB. It rewrites every address bit above its size with a programmable fill value. It splits its span into 256 equal segments, and a programmable 256-entry table gives each segment its own partition number.
- **The wide windows** are sixteen windows that pass addresses through unchanged. Each one either maps its whole span to one programmed partition number, or splits into 256 segments whose index is itself the partition number.

Software programs the windows and the segment table through a simple write port. Lookups are presented with a valid strobe and answered one cycle later. Every window is a naturally aligned power of two: base bits below the window size are ignored. Wide windows are intended to be 256 MB or larger. The programmer must respect that rule and the hardware does not check it.

Top module: `mmio_part_decoder`

## Requirements
- R1: After reset `rsp_valid`, `rsp_hit`, `rsp_addr` and `rsp_part` are zero and every window is disabled, so any lookup misses. Segment table contents are undefined until written.
- R2: A response appears with `rsp_valid` high exactly one cycle after `req_valid`, and `rsp_valid` is low in any cycle that follows a cycle without `req_valid`.
- R3: An enabled window of size 2^L covers an address when the address bits at and above L equal the same bits of the programmed base. Base bits below L are ignored.
- R4: On a narrow-window hit, address bits below L come from the request and bits at and above L come from the fill register.
- R5: The narrow window's segment index is request bits [L-1:L-8]. Its partition number is the segment table entry at that index.
- R6: On a wide-window hit the outbound address equals the request address.
- R7: A segmented wide window (control bit 1 set) returns request bits [L-1:L-8] as the partition number.
- R8: An unsegmented wide window returns its programmed partition number (control bits [15:8]) for every address it covers.
- R9: When several enabled wide windows cover an address, the lowest-numbered one applies. A disabled window never applies.
- R10: When the narrow window and a wide window both cover an address, the narrow window applies.
- R11: An address that no enabled window covers gives `rsp_hit`=0, partition 0 and outbound address 0.
- R12: The top 64 KB of the narrow window is decoded and rewritten like the rest of the window, with no exclusion.
- R13: A lookup presented in the same cycle as a configuration write is decoded with the configuration in force before that write.
- R14: Configuration writes are selected by `cfg_addr[9:8]`, as follows:
  - 00: segment table entry `cfg_addr[7:0]`, with the partition in data[7:0].
  - 01: narrow window. `cfg_addr[1:0]` selects base (0), control (1) or fill (2). The control register holds data[0] enable and data[6:1] L.
  - 10: wide window `cfg_addr[5:2]`, base (0) or control (1). The control register holds data[0] enable, data[1] segmented, data[7:2] L and data[15:8] partition.
  - Writes to other codes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Configuration register select |
| cfg_wdata | input | 64 | Configuration write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | CPU address to decode |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | A window claimed the address |
| rsp_addr | output | ADDR_W | Outbound bus address |
| rsp_part | output | 8 | Partition number |

## Verification
A configuration write and a lookup can fall in the same cycle, and the two may touch the same segment table entry. The bench provokes this by rewriting the table entry of a segment while a lookup of an address inside that segment is strobed on the same edge. It judges the outcome by requiring the old partition number in that response and the new one on the lookup that follows. Priority collisions are provoked the same way, by letting two wide windows and the narrow window cover one address.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  localparam int SEG_BITS = 8;
  localparam int PART_W   = 8;
  localparam int CFG_DW   = 64;

  typedef struct packed {
    logic [PART_W-1:0] part;
    logic [5:0]        l2;
    logic              seg;
    logic              en;
  } w64_ctl_t;

  typedef struct packed {
    logic [5:0] l2;
    logic       en;
  } w32_ctl_t;

  function automatic logic [63:0] low_mask(input logic [5:0] l2);
    return (64'd1 << l2) - 64'd1;
  endfunction

  function automatic logic [SEG_BITS-1:0] seg_of(input logic [63:0] a,
                                                 input logic [5:0]  l2);
    logic [5:0]  sh;
    logic [63:0] t;
    sh = (l2 > 6'd8) ? (l2 - 6'd8) : 6'd0;
    t  = a >> sh;
    return t[SEG_BITS-1:0];
  endfunction
endpackage

// File: rtl/mpd_cfg_regs.sv
module mpd_cfg_regs
  import mpd_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_W64 = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [9:0]                      cfg_addr,
  input  logic [CFG_DW-1:0]               cfg_wdata,
  output logic [ADDR_W-1:0]               w32_base,
  output logic [ADDR_W-1:0]               w32_fill,
  output w32_ctl_t                        w32_ctl,
  output logic [NUM_W64-1:0][ADDR_W-1:0]  w64_base,
  output w64_ctl_t [NUM_W64-1:0]          w64_ctl
);
  localparam int WIN_IW = (NUM_W64 > 1) ? $clog2(NUM_W64) : 1;

  logic [ADDR_W-1:0]              w32_base_n, w32_fill_n;
  w32_ctl_t                       w32_ctl_n;
  logic [NUM_W64-1:0][ADDR_W-1:0] w64_base_n;
  w64_ctl_t [NUM_W64-1:0]         w64_ctl_n;
  logic [WIN_IW-1:0]              win_idx;

  assign win_idx = cfg_addr[2 +: WIN_IW];

  always_comb begin
    w32_base_n = w32_base;
    w32_fill_n = w32_fill;
    w32_ctl_n  = w32_ctl;
    w64_base_n = w64_base;
    w64_ctl_n  = w64_ctl;
    if (cfg_addr[9:8] == 2'b01) begin
      case (cfg_addr[1:0])
        2'd0:    w32_base_n = cfg_wdata[ADDR_W-1:0];
        2'd1:    w32_ctl_n  = w32_ctl_t'(cfg_wdata[6:0]);
        2'd2:    w32_fill_n = cfg_wdata[ADDR_W-1:0];
        default: ;
      endcase
    end else if (cfg_addr[9:8] == 2'b10 && int'(win_idx) < NUM_W64) begin
      case (cfg_addr[1:0])
        2'd0:    w64_base_n[win_idx] = cfg_wdata[ADDR_W-1:0];
        2'd1:    w64_ctl_n[win_idx]  = w64_ctl_t'(cfg_wdata[15:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w32_base <= '0;
      w32_fill <= '0;
      w32_ctl  <= '0;
      w64_base <= '0;
      w64_ctl  <= '0;
    end else if (cfg_we) begin
      w32_base <= w32_base_n;
      w32_fill <= w32_fill_n;
      w32_ctl  <= w32_ctl_n;
      w64_base <= w64_base_n;
      w64_ctl  <= w64_ctl_n;
    end
  end
endmodule

// File: rtl/mpd_seg_table.sv
module mpd_seg_table
  import mpd_pkg::*;
#(
  parameter int NUM_SEG = 1 << SEG_BITS
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [SEG_BITS-1:0]      wr_idx,
  input  logic [PART_W-1:0]        wr_part,
  input  logic [SEG_BITS-1:0]      rd_idx,
  output logic [PART_W-1:0]        rd_part
);
  logic [PART_W-1:0] entry [NUM_SEG];

  always_ff @(posedge clk) begin
    if (wr_en) entry[wr_idx] <= wr_part;
  end

  assign rd_part = entry[rd_idx];
endmodule

// File: rtl/mpd_win64_sel.sv
module mpd_win64_sel
  import mpd_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_W64 = 16
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_W64-1:0][ADDR_W-1:0]  base,
  input  w64_ctl_t [NUM_W64-1:0]          ctl,
  output logic                            hit_any,
  output logic [NUM_W64-1:0]              grant,
  output logic [PART_W-1:0]               part
);
  logic [NUM_W64-1:0]             hit;
  logic [NUM_W64-1:0][PART_W-1:0] wpart;

  for (genvar i = 0; i < NUM_W64; i++) begin : g_win
    logic [ADDR_W-1:0] mask;
    assign mask     = low_mask(ctl[i].l2)[ADDR_W-1:0];
    assign hit[i]   = ctl[i].en && ((addr & ~mask) == (base[i] & ~mask));
    assign wpart[i] = ctl[i].seg ? seg_of(64'(addr), ctl[i].l2) : ctl[i].part;
  end

  always_comb begin
    grant   = '0;
    hit_any = 1'b0;
    part    = '0;
    for (int i = NUM_W64 - 1; i >= 0; i--) begin
      if (hit[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        hit_any  = 1'b1;
        part     = wpart[i];
      end
    end
  end
endmodule

// File: rtl/mmio_part_decoder.sv
module mmio_part_decoder
  import mpd_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_W64 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [9:0]        cfg_addr,
  input  logic [63:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [7:0]        rsp_part
);
  logic [ADDR_W-1:0]              w32_base, w32_fill, mask32, bus32;
  w32_ctl_t                       w32_ctl;
  logic [NUM_W64-1:0][ADDR_W-1:0] w64_base;
  w64_ctl_t [NUM_W64-1:0]         w64_ctl;
  logic                           hit32, hit64_any;
  logic [NUM_W64-1:0]             grant64;
  logic [PART_W-1:0]              part32, part64;
  logic [SEG_BITS-1:0]            seg32;
  logic                           hit_n;
  logic [ADDR_W-1:0]              addr_n;
  logic [PART_W-1:0]              part_n;

  mpd_cfg_regs #(.ADDR_W(ADDR_W), .NUM_W64(NUM_W64)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .w32_base, .w32_fill, .w32_ctl, .w64_base, .w64_ctl
  );

  mpd_seg_table u_tbl (
    .clk     (clk),
    .wr_en   (cfg_we && cfg_addr[9:8] == 2'b00),
    .wr_idx  (cfg_addr[SEG_BITS-1:0]),
    .wr_part (cfg_wdata[PART_W-1:0]),
    .rd_idx  (seg32),
    .rd_part (part32)
  );

  mpd_win64_sel #(.ADDR_W(ADDR_W), .NUM_W64(NUM_W64)) u_w64 (
    .addr    (req_addr),
    .base    (w64_base),
    .ctl     (w64_ctl),
    .hit_any (hit64_any),
    .grant   (grant64),
    .part    (part64)
  );

  assign mask32 = low_mask(w32_ctl.l2)[ADDR_W-1:0];
  assign hit32  = w32_ctl.en && ((req_addr & ~mask32) == (w32_base & ~mask32));
  assign seg32  = seg_of(64'(req_addr), w32_ctl.l2);
  assign bus32  = (w32_fill & ~mask32) | (req_addr & mask32);

  always_comb begin
    hit_n  = 1'b0;
    addr_n = '0;
    part_n = '0;
    if (hit32) begin
      hit_n  = 1'b1;
      addr_n = bus32;
      part_n = part32;
    end else if (hit64_any) begin
      hit_n  = 1'b1;
      addr_n = req_addr;
      part_n = part64;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit  <= 1'b0;
      rsp_addr <= '0;
      rsp_part <= '0;
    end else if (req_valid) begin
      rsp_hit  <= hit_n;
      rsp_addr <= addr_n;
      rsp_part <= part_n;
    end
  end
endmodule

// File: rtl/mmio_part_decoder_chk.sv
module mmio_part_decoder_chk #(
  parameter int ADDR_W  = 48,
  parameter int NUM_W64 = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [ADDR_W-1:0]  rsp_addr,
  input logic [7:0]         rsp_part,
  input logic               hit32,
  input logic               hit64_any,
  input logic [NUM_W64-1:0] grant64
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_MISS_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_part == 8'd0 && rsp_addr == '0)); // R11
  AST_HIT_FROM_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit == $past(hit32 || hit64_any))); // R3
  AST_WIDE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit64_any && !hit32) |=> (rsp_addr == $past(req_addr))); // R6
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant64)); // R9
endmodule

bind mmio_part_decoder mmio_part_decoder_chk #(.ADDR_W(ADDR_W), .NUM_W64(NUM_W64)) u_chk (.*);

// File: tb/mmio_part_decoder_tb.sv
module mmio_part_decoder_tb;
  localparam int AW = 48;
  localparam time CLK_P = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [9:0]    cfg_addr;
  logic [63:0]   cfg_wdata;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          rsp_valid, rsp_hit;
  logic [AW-1:0] rsp_addr;
  logic [7:0]    rsp_part;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  mmio_part_decoder #(.ADDR_W(AW), .NUM_W64(16)) u_dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .req_valid, .req_addr, .rsp_valid, .rsp_hit, .rsp_addr, .rsp_part
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [9:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input string tag, input logic [AW-1:0] a, input logic eh,
                        input logic [AW-1:0] ea, input logic [7:0] ep);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " hit"},   64'(rsp_hit),   64'(eh));
    chk({tag, " addr"},  64'(rsp_addr),  64'(ea));
    chk({tag, " part"},  64'(rsp_part),  64'(ep));
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid at reset", 64'(rsp_valid), 64'd0);
    chk("R1 rsp_part at reset",  64'(rsp_part),  64'd0);
    lookup("R1 no window enabled", 48'h00_0000_1000, 1'b0, '0, 8'h00);
    @(negedge clk);
    chk("R2 idle after response", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_narrow;
    // R14 narrow window: base with stray low bits, L=31, fill with stray low bits
    cfg_write(10'h100, 64'h3F_8000_1234);
    cfg_write(10'h102, 64'h0000_8000_5555);
    cfg_write(10'h101, 64'h3F);
    cfg_write(10'h005, 64'hA5);
    cfg_write(10'h0FF, 64'h3C);
    cfg_write(10'h300, 64'hFFFF);   // R14 unused code, no effect
    lookup("R4 R5 R3 narrow seg5", 48'h3F_8280_1234, 1'b1, 48'h00_8280_1234, 8'hA5);
    lookup("R12 narrow top 64KB",  48'h3F_FFFF_FFF0, 1'b1, 48'h00_FFFF_FFF0, 8'h3C);
    lookup("R11 just above narrow", 48'h40_0000_0000, 1'b0, '0, 8'h00);
  endtask

  task automatic t_wide;
    cfg_write(10'h20C, 64'h10_0000_0000);       // window 3 base
    cfg_write(10'h20D, 64'h83);                 // segmented, L=32
    lookup("R7 R6 wide seg 7", 48'h10_0700_0010, 1'b1, 48'h10_0700_0010, 8'h07);
    lookup("R7 wide last seg", 48'h10_FFFF_FFFF, 1'b1, 48'h10_FFFF_FFFF, 8'hFF);
    cfg_write(10'h204, 64'h10_0000_0000);       // window 1 base
    cfg_write(10'h205, 64'h7779);               // unsegmented, L=30, part 0x77
    lookup("R9 R8 overlap low wins", 48'h10_0700_0010, 1'b1, 48'h10_0700_0010, 8'h77);
    lookup("R9 only window 3",       48'h10_8000_0000, 1'b1, 48'h10_8000_0000, 8'h80);
    cfg_write(10'h205, 64'h7778);               // window 1 disabled
    lookup("R9 disabled ignored",    48'h10_0700_0010, 1'b1, 48'h10_0700_0010, 8'h07);
  endtask

  task automatic t_mixed;
    cfg_write(10'h214, 64'h3F_0000_0000);       // window 5 base
    cfg_write(10'h215, 64'h5581);               // unsegmented, L=32, part 0x55
    lookup("R10 narrow beats wide", 48'h3F_8280_1234, 1'b1, 48'h00_8280_1234, 8'hA5);
    lookup("R8 wide only",          48'h3F_1000_0000, 1'b1, 48'h3F_1000_0000, 8'h55);
    lookup("R11 miss with windows", 48'h20_0000_0000, 1'b0, '0, 8'h00);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 10'h005; cfg_wdata = 64'h5A;
    req_valid = 1'b1; req_addr = 48'h3F_8280_1234;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R13 same-cycle old part", 64'(rsp_part), 64'hA5);
    lookup("R13 next sees new part", 48'h3F_8280_1234, 1'b1, 48'h00_8280_1234, 8'h5A);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_narrow();
    t_wide();
    t_mixed();
    t_same_cycle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule